// File: doc/BRIEF.md
# Memory-Mapped Serial Port

This block is a single-channel asynchronous serial port that a processor drives through a small 32-bit register bus. The bus has a byte address, a read strobe, a write strobe, write data and read data. The processor writes bytes to be sent and reads bytes that have arrived. It polls or takes an interrupt on one status word. A control word with matching bit positions picks which status flags raise the single level interrupt line.

Frames carry 8 data bits, least significant bit first, with no parity and one stop bit. The bit time is a register value that counts system clock cycles per serial bit. Software derives it as the clock frequency divided by the baud rate.

Each direction has one holding register, and there is no FIFO. Beyond data transfer, the port does four further things. It reports errors and overruns in sticky flags that a status write clears. It tracks the CTS input and flags any change on it. It drives an RTS output and can force a break on the transmit line. It flags when a chosen end-of-packet byte passes through either data register.

Top module: `mmio_uart`

## Requirements
- R1: After reset the status word reads 0x060 (bit 6 transmit ready, bit 5 transmitter empty) while CTS is low, irq is 0, txd is 1 and rts is 0.
- R2: Registers sit at byte offsets 0 receive data, 4 transmit data, 8 status, 12 control, 16 divisor and 20 end-of-packet byte. Control, divisor and end-of-packet byte (its low 8 bits) read back what was written.
- R3: A byte written to offset 4 leaves txd as a low start bit, then 8 data bits LSB first, then a high stop bit, each lasting divisor clock cycles.
- R4: Status bit 6 is high only while the transmit holding register is free. Status bit 5 is high only when both the holding register and the shifter are idle.
- R5: A transmit write while bit 6 is low drops the byte and sets bit 4 (transmit overrun) and bit 8 (exception).
- R6: A received frame sets status bit 7 and its byte reads at offset 0. That read clears bit 7.
- R7: A frame completing while bit 7 is still set sets bit 3 (receive overrun) and bit 8. It is discarded, and the earlier byte is kept.
- R8: A frame whose stop bit samples low sets bit 1 (framing error). A frame that is low throughout, stop bit included, also sets bit 2 (break). Both set bit 8.
- R9: Any write to the status register clears bits 0-4, 10 and 12, and with them bit 8.
- R10: irq is high exactly when some status bit at positions 0-8, 10 or 12 and the control bit at the same position are both 1.
- R11: Status bit 11 shows the CTS level through a two-stage synchroniser. Any change of that level sets bit 10.
- R12: Control bit 9 holds txd low. Control bit 11 drives rts.
- R13: Status bit 12 sets when a byte equal to the end-of-packet register's low 8 bits is written to transmit data, or read from receive data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 5 | Byte address inside the 32-byte window |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe (read side effects happen on this cycle) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Level interrupt request |
| rxd | input | 1 | Serial receive line, asynchronous |
| txd | output | 1 | Serial transmit line |
| cts | input | 1 | Clear-to-send input, asynchronous |
| rts | output | 1 | Request-to-send output |

## Verification
The hardest conditions to reach from the ports are the receive error flags. A framing error and a break each need a malformed frame on rxd. A receive overrun needs a second complete frame to arrive before software reads the first. The bench's serial driver can set the stop bit to either level. It sends the all-zero, stop-low break frame and a nonzero frame with a low stop bit, and it sends back-to-back frames with no read between them. The transmit overrun is reached by writing a third byte while one byte is in the shifter and a second one fills the holding register.

// File: rtl/mmio_uart_pkg.sv
// Shared constants for the memory-mapped serial port: status and control
// bit positions (software decodes these) and the register select codes.
package mmio_uart_pkg;
    localparam int SW = 13;                 // status/control word width
    localparam int ST_PE   = 0;
    localparam int ST_FE   = 1;
    localparam int ST_BRK  = 2;
    localparam int ST_ROE  = 3;
    localparam int ST_TOE  = 4;
    localparam int ST_TMT  = 5;
    localparam int ST_TRDY = 6;
    localparam int ST_RRDY = 7;
    localparam int ST_EXC  = 8;
    localparam int ST_DCTS = 10;
    localparam int ST_CTS  = 11;
    localparam int ST_EOP  = 12;
    localparam int CT_TXBRK = 9;
    localparam int CT_RTS   = 11;
    // positions that may raise the interrupt: 0..8, 10, 12
    localparam logic [SW-1:0] IRQ_MASK = 13'b1_0101_1111_1111;

    typedef enum logic [2:0] {
        SEL_RXD  = 3'd0,
        SEL_TXD  = 3'd1,
        SEL_STAT = 3'd2,
        SEL_CTRL = 3'd3,
        SEL_DIV  = 3'd4,
        SEL_EOPC = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/uart_tx_shifter.sv
// Transmit shifter: on load (when idle) sends start, 8 data bits LSB first
// and a stop bit, each lasting div clock cycles. Assumes div >= 2 and that
// div does not change during a frame.
module uart_tx_shifter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             load,
    input  logic [7:0]       din,
    output logic             busy,
    output logic             line
);
    logic [8:0]       shreg;
    logic [DIV_W-1:0] cnt;
    logic [3:0]       bitn;

    // Purpose: frame sequencing, one bit every div cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            cnt   <= '0;
            bitn  <= '0;
            busy  <= 1'b0;
            line  <= 1'b1;
        end else if (!busy) begin
            if (load) begin
                shreg <= {1'b1, din};
                line  <= 1'b0;
                cnt   <= div - DIV_W'(1);
                bitn  <= '0;
                busy  <= 1'b1;
            end
        end else if (cnt == '0) begin
            if (bitn == 4'd9) begin
                busy <= 1'b0;
            end else begin
                line  <= shreg[0];
                shreg <= {1'b1, shreg[8:1]};
                bitn  <= bitn + 4'd1;
                cnt   <= div - DIV_W'(1);
            end
        end else begin
            cnt <= cnt - DIV_W'(1);
        end
    end

    // R3: the line idles high between frames
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> line);
endmodule

// File: rtl/uart_rx_sampler.sv
// Receive sampler: synchronises rxd with two flops, starts on a falling
// edge, re-checks the start bit at mid-bit, then samples 8 data bits and
// the stop bit every div cycles. Pulses done for one cycle with the byte,
// a framing flag (stop low) and a break flag (all bits low).
module uart_rx_sampler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             rxd_async,
    output logic             done,
    output logic [7:0]       data,
    output logic             ferr,
    output logic             brk
);
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;
    rx_st_e           st;
    logic             s1, s2, s3;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;

    // Purpose: two-flop synchroniser plus one delayed copy for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) {s1, s2, s3} <= 3'b111;
        else        {s1, s2, s3} <= {rxd_async, s1, s2};
    end

    // Purpose: frame state machine with mid-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= RX_IDLE; cnt <= '0; bitn <= '0; sh <= '0;
            done <= 1'b0; data <= '0; ferr <= 1'b0; brk <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                RX_IDLE: if (s3 && !s2) begin
                    cnt <= div >> 1;
                    st  <= RX_START;
                end
                RX_START: if (cnt == '0) begin
                    cnt  <= div - DIV_W'(1);
                    bitn <= '0;
                    st   <= s2 ? RX_IDLE : RX_DATA;
                end else cnt <= cnt - DIV_W'(1);
                RX_DATA: if (cnt == '0) begin
                    sh  <= {s2, sh[7:1]};
                    cnt <= div - DIV_W'(1);
                    if (bitn == 3'd7) st <= RX_STOP;
                    else bitn <= bitn + 3'd1;
                end else cnt <= cnt - DIV_W'(1);
                default: if (cnt == '0) begin
                    done <= 1'b1;
                    data <= sh;
                    ferr <= !s2;
                    brk  <= !s2 && (sh == 8'h00);
                    st   <= RX_IDLE;
                end else cnt <= cnt - DIV_W'(1);
            endcase
        end
    end

    // R6: a completed frame is reported for exactly one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a break is always also a framing error
    a_r8_brk_is_ferr: assert property (@(posedge clk) disable iff (!rst_n)
        (done && brk) |-> ferr);
endmodule

// File: rtl/mmio_uart.sv
// Memory-mapped serial port top: register decode, status and control
// words, sticky error flags, CTS synchroniser, end-of-packet match and
// interrupt. Assumes one access per cycle and word-aligned addresses;
// read side effects occur in the cycle rd is high.
module mmio_uart
    import mmio_uart_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int RESET_DIV = 434
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  addr,
    input  logic        wr,
    input  logic        rd,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    input  logic        rxd,
    output logic        txd,
    input  logic        cts,
    output logic        rts
);
    logic [SW-1:0]    ctrl, status;
    logic [DIV_W-1:0] div;
    logic [7:0]       eop_c, rx_buf, tx_hold;
    logic             rrdy, fe, brk, roe, toe, dcts, eop, hold_full;
    logic             cts_s1, cts_s2, cts_s3;
    logic             tx_busy, tx_line, tx_load;
    logic             rx_done, rx_ferr, rx_brk;
    logic [7:0]       rx_byte;
    logic             aligned, wr_rxd, wr_txd, wr_stat, wr_ctrl, wr_div, wr_eopc;
    logic             rd_rxd;
    reg_sel_e         sel;
    logic             unused_wbits;

    assign unused_wbits = ^wdata[31:SW];
    assign sel     = reg_sel_e'(addr[4:2]);
    assign aligned = (addr[1:0] == 2'b00);
    assign wr_rxd  = 1'b0;
    assign wr_txd  = wr && aligned && sel == SEL_TXD;
    assign wr_stat = wr && aligned && sel == SEL_STAT;
    assign wr_ctrl = wr && aligned && sel == SEL_CTRL;
    assign wr_div  = wr && aligned && sel == SEL_DIV;
    assign wr_eopc = wr && aligned && sel == SEL_EOPC;
    assign rd_rxd  = rd && aligned && sel == SEL_RXD && !wr_rxd;
    assign tx_load = hold_full && !tx_busy;

    uart_tx_shifter #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .div(div), .load(tx_load), .din(tx_hold),
        .busy(tx_busy), .line(tx_line));

    uart_rx_sampler #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .div(div), .rxd_async(rxd),
        .done(rx_done), .data(rx_byte), .ferr(rx_ferr), .brk(rx_brk));

    // Purpose: assemble the status word from flags and live conditions.
    always_comb begin
        status           = '0;
        status[ST_PE]    = 1'b0;
        status[ST_FE]    = fe;
        status[ST_BRK]   = brk;
        status[ST_ROE]   = roe;
        status[ST_TOE]   = toe;
        status[ST_TMT]   = !hold_full && !tx_busy;
        status[ST_TRDY]  = !hold_full;
        status[ST_RRDY]  = rrdy;
        status[ST_EXC]   = fe | brk | roe | toe;
        status[ST_DCTS]  = dcts;
        status[ST_CTS]   = cts_s2;
        status[ST_EOP]   = eop;
    end

    assign irq = |(status & ctrl & IRQ_MASK);
    assign txd = ctrl[CT_TXBRK] ? 1'b0 : tx_line;
    assign rts = ctrl[CT_RTS];

    // Purpose: combinational read multiplexer.
    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (sel)
                SEL_RXD:  rdata = {24'd0, rx_buf};
                SEL_STAT: rdata = {{(32-SW){1'b0}}, status};
                SEL_CTRL: rdata = {{(32-SW){1'b0}}, ctrl};
                SEL_DIV:  rdata = {{(32-DIV_W){1'b0}}, div};
                SEL_EOPC: rdata = {24'd0, eop_c};
                default:  rdata = '0;
            endcase
        end
    end

    // Purpose: CTS two-stage synchroniser and one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) {cts_s1, cts_s2, cts_s3} <= 3'b000;
        else        {cts_s1, cts_s2, cts_s3} <= {cts, cts_s1, cts_s2};
    end

    // Purpose: plain configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            div   <= DIV_W'(RESET_DIV);
            eop_c <= '0;
        end else begin
            if (wr_ctrl) ctrl  <= wdata[SW-1:0];
            if (wr_div)  div   <= wdata[DIV_W-1:0];
            if (wr_eopc) eop_c <= wdata[7:0];
        end
    end

    // Purpose: transmit holding register and transmit overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0; hold_full <= 1'b0;
        end else begin
            if (tx_load) hold_full <= 1'b0;
            if (wr_txd && !hold_full) begin
                tx_hold   <= wdata[7:0];
                hold_full <= 1'b1;
            end
        end
    end

    // Purpose: receive buffer and all sticky flags (status write clears first,
    // new events then set).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf <= '0; rrdy <= 1'b0;
            fe <= 1'b0; brk <= 1'b0; roe <= 1'b0; toe <= 1'b0;
            dcts <= 1'b0; eop <= 1'b0;
        end else begin
            if (wr_stat) begin
                fe <= 1'b0; brk <= 1'b0; roe <= 1'b0; toe <= 1'b0;
                dcts <= 1'b0; eop <= 1'b0;
            end
            if (rd_rxd) rrdy <= 1'b0;
            if (rx_done) begin
                if (rrdy && !rd_rxd) roe <= 1'b1;
                else begin
                    rx_buf <= rx_byte;
                    rrdy   <= 1'b1;
                end
                if (rx_ferr) fe  <= 1'b1;
                if (rx_brk)  brk <= 1'b1;
            end
            if (wr_txd && hold_full) toe <= 1'b1;
            if (cts_s2 != cts_s3) dcts <= 1'b1;
            if ((wr_txd && wdata[7:0] == eop_c) ||
                (rd_rxd && rrdy && rx_buf == eop_c)) eop <= 1'b1;
        end
    end

    // R7: a frame arriving over an unread byte flags overrun and keeps the old byte
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rrdy && !rd_rxd) |=> (roe && $stable(rx_buf)));
    // R4: accepting a byte makes the holding register busy on the next cycle
    a_r4_trdy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && status[ST_TRDY]) |=> !status[ST_TRDY]);
    // R6: reading receive data clears receive ready unless a new frame lands
    a_r6_rrdy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && !rx_done) |=> !status[ST_RRDY]);
    // R9: a status write leaves every error flag clear
    a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !rx_done) |=> (status[ST_TOE:ST_PE] == '0 && !status[ST_EXC]));
endmodule

// File: tb/mmio_uart_test.sv
module mmio_uart_test;
    localparam int BIT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, txd, rts;
    logic        rxd = 1'b1, cts = 1'b0;

    int tests = 0, fails = 0;
    bit mon_en = 1'b1;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #4 clk = ~clk;

    mmio_uart #(.DIV_W(16), .RESET_DIV(434)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd),
        .wdata(wdata), .rdata(rdata), .irq(irq), .rxd(rxd), .txd(txd),
        .cts(cts), .rts(rts));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic send_tx(input logic [7:0] b);
        tx_q.push_back(b);
        wr_reg(5'd4, {24'd0, b});
    endtask

    // driver: drives one frame on rxd; stop bit level selectable
    task automatic send_rx(input logic [7:0] b, input logic stop);
        @(negedge clk); rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = stop;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // scoreboard pop for the receive path (R6)
    task automatic read_rx(input string tag);
        logic [31:0] d;
        logic [7:0]  e;
        rd_reg(5'd0, d);
        e = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hxx;
        check(tag, d, {24'd0, e});
    endtask

    // monitor: decode frames on txd and compare with the expected queue (R3)
    initial begin
        forever begin
            @(negedge txd);
            if (mon_en) begin
                logic [7:0] got;
                logic [7:0] exp;
                repeat (BIT/2) @(negedge clk);
                check("R3 start bit", {31'd0, txd}, 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT) @(negedge clk);
                    got[i] = txd;
                end
                repeat (BIT) @(negedge clk);
                check("R3 stop bit", {31'd0, txd}, 32'd1);
                exp = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hxx;
                check("R3 tx byte", {24'd0, got}, {24'd0, exp});
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        rd_reg(5'd8, d);  check("R1 status", d, 32'h060);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 txd", {31'd0, txd}, 1);
        check("R1 rts", {31'd0, rts}, 0);
        rd_reg(5'd16, d); check("R2 divisor reset", d, 32'd434);

        // R2 register readback
        wr_reg(5'd16, BIT);
        rd_reg(5'd16, d); check("R2 divisor", d, BIT);
        wr_reg(5'd20, 32'h10D);
        rd_reg(5'd20, d); check("R2 eop byte", d, 32'h0D);
        wr_reg(5'd12, 32'h0);
        rd_reg(5'd12, d); check("R2 control", d, 0);

        // R3/R4/R5 transmit, holding register full, overrun
        send_tx(8'h55);
        rd_reg(5'd8, d); check("R4 tmt low while shifting", d[5], 0);
        send_tx(8'hA3);
        rd_reg(5'd8, d); check("R4 trdy low when holding full", d[6], 0);
        wr_reg(5'd4, 32'h77);      // dropped
        rd_reg(5'd8, d); check("R5 toe", d[4], 1);
        check("R5 exception", d[8], 1);
        repeat (BIT*10*2 + 40) @(negedge clk);
        rd_reg(5'd8, d); check("R4 idle with toe", d, 32'h170);
        check("R3 tx queue drained", tx_q.size(), 0);

        // R9 status write clears
        wr_reg(5'd8, 32'h0);
        rd_reg(5'd8, d); check("R9 cleared", d, 32'h060);

        // R6 receive
        rx_q.push_back(8'h3C); send_rx(8'h3C, 1'b1);
        rd_reg(5'd8, d); check("R6 rrdy", d, 32'h0E0);
        read_rx("R6 rx byte");
        rd_reg(5'd8, d); check("R6 rrdy cleared", d, 32'h060);

        // R7 overrun
        rx_q.push_back(8'h11); send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        rd_reg(5'd8, d); check("R7 roe", d, 32'h1E8);
        read_rx("R7 first byte kept");
        wr_reg(5'd8, 32'h0);

        // R8 framing error and break
        rx_q.push_back(8'hF0); send_rx(8'hF0, 1'b0);
        rd_reg(5'd8, d); check("R8 framing", d, 32'h1E2);
        read_rx("R8 framing byte");
        wr_reg(5'd8, 32'h0);
        rx_q.push_back(8'h00); send_rx(8'h00, 1'b0);
        rd_reg(5'd8, d); check("R8 break", d, 32'h1E6);
        read_rx("R8 break byte");
        wr_reg(5'd8, 32'h0);
        rd_reg(5'd8, d); check("R9 cleared after break", d, 32'h060);

        // R10 interrupt
        wr_reg(5'd12, 32'h080);
        check("R10 no irq idle", {31'd0, irq}, 0);
        rx_q.push_back(8'h5A); send_rx(8'h5A, 1'b1);
        check("R10 irq on rrdy", {31'd0, irq}, 1);
        read_rx("R10 rx byte");
        check("R10 irq after read", {31'd0, irq}, 0);
        wr_reg(5'd12, 32'h0);
        rx_q.push_back(8'hC3); send_rx(8'hC3, 1'b1);
        check("R10 masked", {31'd0, irq}, 0);
        read_rx("R10 masked byte");
        wr_reg(5'd12, 32'h040);
        check("R10 irq on trdy", {31'd0, irq}, 1);
        wr_reg(5'd12, 32'h0);

        // R11 CTS
        @(negedge clk); cts = 1'b1;
        repeat (4) @(negedge clk);
        rd_reg(5'd8, d); check("R11 cts change", d, 32'hC60);
        wr_reg(5'd12, 32'h400);
        check("R10 R11 irq on cts change", {31'd0, irq}, 1);
        wr_reg(5'd8, 32'h0);
        rd_reg(5'd8, d); check("R11 change cleared", d, 32'h860);
        check("R11 irq gone", {31'd0, irq}, 0);

        // R12 rts and forced break
        wr_reg(5'd12, 32'h800);
        check("R12 rts", {31'd0, rts}, 1);
        mon_en = 1'b0;
        wr_reg(5'd12, 32'h200);
        check("R12 break", {31'd0, txd}, 0);
        wr_reg(5'd12, 32'h0);
        check("R12 break released", {31'd0, txd}, 1);
        repeat (4) @(negedge clk);
        mon_en = 1'b1;

        // R13 end-of-packet
        send_tx(8'h0D);
        rd_reg(5'd8, d); check("R13 eop on tx", d[12], 1);
        repeat (BIT*10 + 40) @(negedge clk);
        wr_reg(5'd8, 32'h0);
        rx_q.push_back(8'h0D); send_rx(8'h0D, 1'b1);
        rd_reg(5'd8, d); check("R13 no eop before read", d, 32'h8E0);
        read_rx("R13 rx byte");
        rd_reg(5'd8, d); check("R13 eop on rx read", d, 32'h1860);

        repeat (20) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule